// File: doc/BRIEF.md
# Ping-Pong Line Buffer Serializer Framer

This block sits between a group of sixteen column converters and one serial output lane. Each column result is a 10-bit word. Words arriving during a line time are stored in one of two line banks. On every line-start pulse the banks change roles. The bank that was just filled is sent out on the lane as one burst, and the converters start filling the other bank.

Every burst begins with a fixed 12-bit synchronisation word, 0x50F. The sixteen pixel words follow in the order in which they were written, and every field is sent most significant bit first. A burst therefore lasts 172 clock cycles. Between bursts the lane rests low with its valid flag low.

A test mode replaces the pixel words with constant patterns. The patterns alternate from line to line, so the receiver can check word alignment and bit polarity. A line start that arrives before the running burst has sent its last bit sets a sticky overrun flag. The running burst is dropped and the new one starts from its header.

Top module: `pixel_lane_framer`

## Requirements
- R1: While reset is held and after its release, ser_valid, ser_bit and overrun are all 0.
- R2: A line_start sampled at a clock edge makes ser_valid 1 after that same edge. ser_valid then stays 1 for exactly 172 consecutive cycles.
- R3: The first 12 bits of every burst are the header 0x50F, sent MSB first. This holds in both normal and test mode.
- R4: After the header come 16 words of 10 bits, MSB first, for columns 0 to 15. The columns are numbered in the order the words were written during the line time before the line_start that began the burst.
- R5: Words written while a burst is being sent go to the other bank and do not change the burst in progress.
- R6: Once 16 words have been written in one line time, further writes in that line time are ignored. The earlier columns keep their values.
- R7: A write in the same cycle as line_start is stored as column 0 of the new line.
- R8: If test_en is 1 when line_start is sampled, the burst's 16 words are all a test pattern. The first test line after normal mode uses 0x3F0. Each following consecutive test line alternates between 0x00F and 0x3F0.
- R9: A line_start sampled with test_en at 0 resets the alternation, so the next test line uses 0x3F0 again.
- R10: Whenever ser_valid is 0, ser_bit is 0.
- R11: A line_start sampled while the current burst has not yet shown its last bit sets overrun. The flag stays set until reset, and the new burst starts from the header. A line_start in the cycle right after the last bit is shown does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Converter write strobe |
| wr_data | input | 10 | Converter result word |
| line_start | input | 1 | One-cycle line-time pulse; swaps banks and starts a burst |
| test_en | input | 1 | Selects test patterns for the burst started by line_start |
| ser_bit | output | 1 | Serial lane bit |
| ser_valid | output | 1 | High while ser_bit carries a burst bit |
| overrun | output | 1 | Sticky flag: a line started before the previous burst ended |

## Verification
The assertions assume that line_start is a single-cycle pulse and that reset is synchronous. Under these assumptions the rising edge of ser_valid always shows the header MSB, and a rising overrun can be traced to a line_start seen while a burst was active.

The stimulus keeps line_start one cycle wide and spaces line times to cover three cases: a full burst length, the exact back-to-back limit, and one deliberately short gap that triggers the overrun. Writes include full lines, overlong lines, writes during bursts, and a write that coincides with line_start. Columns that were never written are treated by the reference model as unknown and are not compared.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    SRC_PIX   = 2'd0,
    SRC_PAT_A = 2'd1,
    SRC_PAT_B = 2'd2
  } word_src_e;

  localparam int          DEF_COLS  = 16;
  localparam int          DEF_PIX_W = 10;
  localparam int          DEF_HDR_W = 12;
  localparam logic [11:0] DEF_HDR   = 12'h50F;
  localparam logic [9:0]  DEF_PAT   = 10'h3F0;
endpackage

// File: rtl/line_bank_ram.sv
module line_bank_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int               COLS    = 16,
  parameter int               PIX_W   = 10,
  parameter int               HDR_W   = 12,
  parameter logic [HDR_W-1:0] HDR_VAL = 12'h50F,
  localparam int AW = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PIX_W-1:0] word,
  output logic [AW-1:0]    rd_addr,
  output logic             ser_bit,
  output logic             ser_valid,
  output logic             burst_open
);
  localparam int SH_W = (HDR_W > PIX_W) ? HDR_W : PIX_W;
  localparam int CW   = $clog2(COLS + 1);
  localparam int BW   = $clog2(SH_W);
  localparam logic [SH_W-1:0] HDR_AL = SH_W'(HDR_VAL) << (SH_W - HDR_W);

  logic [SH_W-1:0] sh;
  logic [BW-1:0]   bcnt;
  logic            in_hdr;
  logic [CW-1:0]   wptr;
  logic            unit_end, last;

  assign unit_end   = in_hdr ? (bcnt == BW'(HDR_W - 1)) : (bcnt == BW'(PIX_W - 1));
  assign last       = !in_hdr && unit_end && (wptr == CW'(COLS));
  assign burst_open = ser_valid && !last;
  assign ser_bit    = sh[SH_W-1];
  assign rd_addr    = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bcnt      <= '0;
      in_hdr    <= 1'b0;
      wptr      <= '0;
      ser_valid <= 1'b0;
    end else if (start) begin
      sh        <= HDR_AL;
      bcnt      <= '0;
      in_hdr    <= 1'b1;
      wptr      <= '0;
      ser_valid <= 1'b1;
    end else if (ser_valid) begin
      if (last) begin
        sh        <= '0;
        ser_valid <= 1'b0;
      end else if (unit_end) begin
        sh     <= SH_W'(word) << (SH_W - PIX_W);
        bcnt   <= '0;
        in_hdr <= 1'b0;
        wptr   <= wptr + 1'b1;
      end else begin
        sh   <= sh << 1;
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |-> !ser_bit);

  p_hdr_msb_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_valid) |-> ser_bit == HDR_VAL[HDR_W-1]);
endmodule

// File: rtl/pixel_lane_framer.sv
module pixel_lane_framer
  import lane_pkg::*;
#(
  parameter int               COLS    = DEF_COLS,
  parameter int               PIX_W   = DEF_PIX_W,
  parameter int               HDR_W   = DEF_HDR_W,
  parameter logic [HDR_W-1:0] HDR_VAL = DEF_HDR,
  parameter logic [PIX_W-1:0] PAT_VAL = DEF_PAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             line_start,
  input  logic             test_en,
  output logic             ser_bit,
  output logic             ser_valid,
  output logic             overrun
);
  localparam int AW    = $clog2(COLS);
  localparam int CW    = $clog2(COLS + 1);
  localparam int DEPTH = 2 * (2 ** AW);

  logic             bank_sel;
  logic [CW-1:0]    wr_ptr;
  logic             tst_phase;
  word_src_e        src;
  logic             ram_we, burst_open;
  logic [AW:0]      ram_waddr, ram_raddr;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] ram_q, word;

  // write bank = bank_sel, read bank = ~bank_sel
  assign ram_we    = wr_en && (line_start || (wr_ptr < CW'(COLS)));
  assign ram_waddr = line_start ? {~bank_sel, {AW{1'b0}}} : {bank_sel, wr_ptr[AW-1:0]};
  assign ram_raddr = {~bank_sel, rd_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel  <= 1'b0;
      wr_ptr    <= '0;
      tst_phase <= 1'b0;
      src       <= SRC_PIX;
      overrun   <= 1'b0;
    end else if (line_start) begin
      bank_sel <= ~bank_sel;
      wr_ptr   <= wr_en ? CW'(1) : '0;
      if (test_en) begin
        src       <= tst_phase ? SRC_PAT_B : SRC_PAT_A;
        tst_phase <= ~tst_phase;
      end else begin
        src       <= SRC_PIX;
        tst_phase <= 1'b0;
      end
      if (burst_open) overrun <= 1'b1;
    end else if (ram_we) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_comb begin
    case (src)
      SRC_PAT_A: word = PAT_VAL;
      SRC_PAT_B: word = ~PAT_VAL;
      default:   word = ram_q;
    endcase
  end

  line_bank_ram #(.W(PIX_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(wr_data),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  lane_shifter #(.COLS(COLS), .PIX_W(PIX_W), .HDR_W(HDR_W), .HDR_VAL(HDR_VAL)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (line_start),
    .word      (word),
    .rd_addr   (rd_addr),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .burst_open(burst_open)
  );

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> ser_valid && ser_bit == HDR_VAL[HDR_W-1]);

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_overrun_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(line_start) && $past(ser_valid));
endmodule

// File: tb/pixel_lane_framer_bench.sv
module pixel_lane_framer_bench;
  localparam int          COLS = 16;
  localparam int          PW   = 10;
  localparam int          HW   = 12;
  localparam logic [11:0] HDR  = 12'h50F;
  localparam logic [9:0]  PA   = 10'h3F0;

  logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, line_start = 1'b0, test_en = 1'b0;
  logic [PW-1:0] wr_data = '0;
  logic          ser_bit, ser_valid, overrun;

  always #4 clk = ~clk;

  pixel_lane_framer u_pixel_lane_framer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .line_start(line_start),
    .test_en(test_en), .ser_bit(ser_bit), .ser_valid(ser_valid), .overrun(overrun)
  );

  int    n_chk = 0, n_fail = 0, cycles = 0;
  string tag = "R1 reset";

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // behavioural reference: queue of bits still to appear on the lane
  bit            mq[$];
  bit            mk[$];
  logic [PW-1:0] mb[2][COLS];
  bit            mkn[2][COLS];
  int            m_bank, m_ptr;
  bit            m_phase, m_ovr, use_pat, dmy;
  logic [PW-1:0] pat;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mk.delete();
      m_bank = 0; m_ptr = 0; m_phase = 0; m_ovr = 0;
      for (int b = 0; b < 2; b++) for (int c = 0; c < COLS; c++) mkn[b][c] = 0;
    end else begin
      if (mq.size() > 0) begin dmy = mq.pop_front(); dmy = mk.pop_front(); end
      if (line_start) begin
        if (mq.size() > 0) m_ovr = 1;
        mq.delete(); mk.delete();
        use_pat = test_en;
        pat = m_phase ? ~PA : PA;
        if (test_en) m_phase = ~m_phase; else m_phase = 0;
        for (int i = HW - 1; i >= 0; i--) begin mq.push_back(HDR[i]); mk.push_back(1'b1); end
        for (int c = 0; c < COLS; c++)
          for (int b = PW - 1; b >= 0; b--) begin
            if (use_pat) begin mq.push_back(pat[b]); mk.push_back(1'b1); end
            else begin mq.push_back(mb[m_bank][c][b] === 1'b1); mk.push_back(mkn[m_bank][c]); end
          end
        m_bank = 1 - m_bank;
        m_ptr  = 0;
      end
      if (wr_en && m_ptr < COLS) begin
        mb[m_bank][m_ptr]  = wr_data;
        mkn[m_bank][m_ptr] = 1;
        m_ptr++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(tag, "ser_valid", 32'(ser_valid), 32'(mq.size() > 0));
      if (mq.size() > 0) begin
        if (mk[0]) chk(tag, "ser_bit", 32'(ser_bit), 32'(mq[0]));
      end else chk(tag, "idle ser_bit", 32'(ser_bit), 32'd0);
      chk(tag, "overrun", 32'(overrun), 32'(m_ovr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic write_line(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = PW'(seed + i * 53);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start(input bit tm);
    @(negedge clk);
    line_start = 1'b1;
    test_en    = tm;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ser_valid in reset", 32'(ser_valid), 32'd0);
    chk("R1", "ser_bit in reset", 32'(ser_bit), 32'd0);
    chk("R1", "overrun in reset", 32'(overrun), 32'd0);
    rst = 1'b0;
    idle(2);
    chk("R1", "ser_valid after reset", 32'(ser_valid), 32'd0);

    tag = "R2 R3 R4 first line";
    write_line(16, 100);
    pulse_start(1'b0);
    tag = "R5 R6 writes during burst";
    write_line(19, 7);
    idle(160);
    tag = "R10 idle";
    idle(6);
    tag = "R4 R6 second line";
    pulse_start(1'b0);
    idle(178);

    tag = "R7 write with line start";
    @(negedge clk);
    line_start = 1'b1; wr_en = 1'b1; wr_data = 10'h2AA;
    @(negedge clk);
    line_start = 1'b0; wr_data = 10'h111;
    @(negedge clk);
    wr_en = 1'b0;
    idle(175);
    pulse_start(1'b0);
    idle(178);

    tag = "R8 test patterns";
    pulse_start(1'b1); idle(176);
    pulse_start(1'b1); idle(176);
    pulse_start(1'b1); idle(176);
    tag = "R9 phase reset";
    pulse_start(1'b0); idle(176);
    pulse_start(1'b1); idle(176);

    tag = "R11 back to back no overrun";
    write_line(16, 301);
    pulse_start(1'b0);
    idle(170);
    pulse_start(1'b0);
    idle(5);
    chk("R11", "overrun after exact back-to-back", 32'(overrun), 32'd0);
    idle(170);

    tag = "R11 overrun";
    pulse_start(1'b0);
    idle(40);
    pulse_start(1'b0);
    idle(200);
    chk("R11", "overrun sticky", 32'(overrun), 32'd1);
    tag = "R10 R11 final idle";
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule